// File: doc/BRIEF.md
# Converter Calibration Sequencer

This control block drives the start-up and recalibration steps of a data converter core. After a synchronous reset it waits a fixed number of master clock cycles and then samples a strap input once, to decide whether the core runs in register-control operation or stand-alone operation. From then on, the block answers calibration requests from outside.

A calibration request arrives asynchronously on `cal_req_in`. It passes through a synchronizer whose latency is fixed, so every device that shares the master clock and the request starts its sequence on the same clock edge. The sequence is:

1. A one-cycle frame-alignment pulse.
2. Ground calibration is raised.
3. A one-cycle calibration start pulse follows.
4. The block counts sample-frame ticks. The count it waits for depends on the oversampling mode.
5. Ground calibration is released.

A busy flag covers the whole sequence. Requests that arrive while busy is high are dropped.

Top module: `cal_sequencer`

## Requirements
- R1: While reset is high and in the cycle after it, the outputs `sync_o`, `gndcal_o`, `cal_o`, `busy_o`, `mode_valid_o` and `ctrl_mode_o` are all 0.
- R2: The strap is captured on the 250th rising clock edge after reset is released, and `mode_valid_o` rises on that edge. `ctrl_mode_o` takes the strap value (1 = register-control, 0 = stand-alone). Later strap changes have no effect until the next reset.
- R3: Calibration requests seen before `mode_valid_o` is 1 start nothing.
- R4: A sequence starts only on a low-to-high change of `cal_req_in`. Take the first rising edge at which the request is sampled high. `sync_o` is 1 in the cycle after the third such edge, counting that first one, and is 0 before it.
- R5: `sync_o` is high for exactly one cycle. `gndcal_o` rises in the next cycle. In the cycle after that, `cal_o` pulses high for exactly one cycle. `gndcal_o` stays high through the pulse.
- R6: After the `cal_o` cycle, the block counts clocks with `lr_tick` high. `gndcal_o` falls in the cycle after the edge that samples the N-th tick, where N is 2050 in the 128x mode and 4100 in the 64x mode.
- R7: `os128_sel` (1 = 128x, 0 = 64x) is sampled only in the `cal_o` cycle. Changes during the wait leave N unchanged.
- R8: `busy_o` is high from the `sync_o` cycle until `gndcal_o` falls. A request that rises while busy starts no later sequence, and `sync_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_in | input | 1 | Mode strap, sampled once after reset |
| cal_req_in | input | 1 | Asynchronous calibration request |
| os128_sel | input | 1 | 1 selects 128x oversampling, 0 selects 64x |
| lr_tick | input | 1 | One-cycle pulse per sample frame |
| ctrl_mode_o | output | 1 | Captured strap value |
| mode_valid_o | output | 1 | Strap has been captured |
| sync_o | output | 1 | Frame-alignment pulse |
| gndcal_o | output | 1 | Ground calibration control |
| cal_o | output | 1 | Calibration start pulse |
| busy_o | output | 1 | Sequence in progress |

## Verification
The bench checks the strap capture one edge before and on the 250th edge. A design that is off by one there reports the mode early, or misses it. It checks the synchronizer latency edge by edge, because any spread in that latency would skew devices that share a request. For each mode, the wait is checked at tick N-1 and at tick N, with random gaps between ticks. It also flips the mode select partway through a wait, and raises requests while busy. A design that used the live mode bit, or that restarted on a late request, would end the wait at the wrong tick or emit a stray sync pulse.

// File: rtl/calseq_pkg.sv
package calseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_GND,
        ST_CAL,
        ST_WAIT
    } seq_state_t;

    typedef struct packed {
        logic sync;
        logic gnd;
        logic cal;
        logic busy;
    } seq_ctrl_t;

    function automatic seq_ctrl_t decode_ctrl(seq_state_t s);
        seq_ctrl_t c;
        c.sync = (s == ST_SYNC);
        c.gnd  = (s == ST_GND) || (s == ST_CAL) || (s == ST_WAIT);
        c.cal  = (s == ST_CAL);
        c.busy = (s != ST_IDLE);
        return c;
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/strap_sampler.sv
module strap_sampler #(
    parameter int unsigned DELAY = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic strap_in,
    output logic mode_o,
    output logic valid_o
);
    localparam int CW = $clog2(DELAY + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            mode_o  <= 1'b0;
            valid_o <= 1'b0;
        end else if (!valid_o) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(DELAY - 1)) begin
                mode_o  <= strap_in;
                valid_o <= 1'b1;
            end
        end
    end

    assert_mode_held_R2: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> valid_o && $stable(mode_o));

endmodule

// File: rtl/req_retimer.sv
module req_retimer #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req_async,
    output logic req_pulse
);
    logic [STAGES:0] pipe_q;

    genvar g;
    generate
        for (g = 0; g <= STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) pipe_q[0] <= 1'b0;
                    else     pipe_q[0] <= req_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) pipe_q[g] <= 1'b0;
                    else     pipe_q[g] <= pipe_q[g-1];
                end
            end
        end
    endgenerate

    assign req_pulse = pipe_q[STAGES-1] & ~pipe_q[STAGES];

    assert_pulse_single_R4: assert property (@(posedge clk) disable iff (rst)
        req_pulse |=> !req_pulse);

endmodule

// File: rtl/frame_counter.sv
module frame_counter #(
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          count_en,
    input  logic [CW-1:0] limit,
    output logic          hit
);
    logic [CW-1:0] cnt_q;

    assign hit = count_en && (cnt_q == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || clear) cnt_q <= '0;
        else if (hit)     cnt_q <= '0;
        else if (count_en) cnt_q <= cnt_q + 1'b1;
    end

    assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst || clear)
        cnt_q < limit);

endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer
    import calseq_pkg::*;
#(
    parameter int unsigned STRAP_DELAY = 250,
    parameter int unsigned WAIT_128    = 2050,
    parameter int unsigned WAIT_64     = 4100,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strap_in,
    input  logic cal_req_in,
    input  logic os128_sel,
    input  logic lr_tick,
    output logic ctrl_mode_o,
    output logic mode_valid_o,
    output logic sync_o,
    output logic gndcal_o,
    output logic cal_o,
    output logic busy_o
);
    localparam int unsigned WAIT_MAX = max_u(WAIT_128, WAIT_64);
    localparam int CW = $clog2(WAIT_MAX + 1);

    seq_state_t    state_q, state_d;
    seq_ctrl_t     ctrl;
    logic          req_pulse;
    logic          wait_hit;
    logic [CW-1:0] limit_q;

    strap_sampler #(.DELAY(STRAP_DELAY)) u_strap (
        .clk     (clk),
        .rst     (rst),
        .strap_in(strap_in),
        .mode_o  (ctrl_mode_o),
        .valid_o (mode_valid_o)
    );

    req_retimer #(.STAGES(SYNC_STAGES)) u_retime (
        .clk      (clk),
        .rst      (rst),
        .req_async(cal_req_in),
        .req_pulse(req_pulse)
    );

    frame_counter #(.CW(CW)) u_frames (
        .clk     (clk),
        .rst     (rst),
        .clear   (state_q == ST_CAL),
        .count_en((state_q == ST_WAIT) && lr_tick),
        .limit   (limit_q),
        .hit     (wait_hit)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_pulse && mode_valid_o) state_d = ST_SYNC;
            ST_SYNC: state_d = ST_GND;
            ST_GND:  state_d = ST_CAL;
            ST_CAL:  state_d = ST_WAIT;
            ST_WAIT: if (wait_hit) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            limit_q <= CW'(WAIT_64);
        end else begin
            state_q <= state_d;
            if (state_q == ST_CAL)
                limit_q <= os128_sel ? CW'(WAIT_128) : CW'(WAIT_64);
        end
    end

    assign ctrl     = decode_ctrl(state_q);
    assign sync_o   = ctrl.sync;
    assign gndcal_o = ctrl.gnd;
    assign cal_o    = ctrl.cal;
    assign busy_o   = ctrl.busy;

    assert_sync_then_gnd_R5: assert property (@(posedge clk) disable iff (rst)
        sync_o |=> gndcal_o && !sync_o);
    assert_gnd_after_sync_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(gndcal_o) |-> $past(sync_o));
    assert_cal_inside_gnd_R5: assert property (@(posedge clk) disable iff (rst)
        cal_o |-> gndcal_o);
    assert_release_on_count_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(gndcal_o) |-> $past(wait_hit));
    assert_no_start_early_R3: assert property (@(posedge clk) disable iff (rst)
        !mode_valid_o |=> !sync_o);
    assert_busy_covers_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sync_o, cal_o}) && (gndcal_o || sync_o) == busy_o);

endmodule

// File: tb/cal_sequencer_tb_top.sv
module cal_sequencer_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic strap_in = 1'b0, cal_req_in = 1'b0, os128_sel = 1'b0, lr_tick = 1'b0;
    logic ctrl_mode_o, mode_valid_o, sync_o, gndcal_o, cal_o, busy_o;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    logic stray_sync;

    always #10 clk = ~clk;

    cal_sequencer dut_i (
        .clk(clk), .rst(rst), .strap_in(strap_in), .cal_req_in(cal_req_in),
        .os128_sel(os128_sel), .lr_tick(lr_tick), .ctrl_mode_o(ctrl_mode_o),
        .mode_valid_o(mode_valid_o), .sync_o(sync_o), .gndcal_o(gndcal_o),
        .cal_o(cal_o), .busy_o(busy_o)
    );

    function automatic int unsigned frames_needed(logic os128);
        return os128 ? 2050 : 4100;
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset(input logic strap);
        rst = 1'b1;
        strap_in = strap;
        step(3);
        check({sync_o, gndcal_o, cal_o, busy_o, mode_valid_o, ctrl_mode_o} == 6'b0,
              "R1 reset outputs", {sync_o, gndcal_o, cal_o, busy_o, mode_valid_o, ctrl_mode_o}, 0);
        rst = 1'b0;
        step(1);
        check(busy_o == 1'b0 && mode_valid_o == 1'b0, "R1 after reset", busy_o, 0);
        step(248);
        check(mode_valid_o == 1'b0, "R2 not valid at edge 249", mode_valid_o, 0);
        step(1);
        check(mode_valid_o == 1'b1, "R2 valid at edge 250", mode_valid_o, 1);
        check(ctrl_mode_o == strap, "R2 strap value", ctrl_mode_o, strap);
        strap_in = ~strap;
        step(5);
        check(ctrl_mode_o == strap, "R2 later strap ignored", ctrl_mode_o, strap);
    endtask

    // Drive n frame ticks with random gaps; record any sync pulse seen meanwhile.
    task automatic drive_ticks(input int unsigned n, input logic flip_mode);
        for (int unsigned k = 0; k < n; k++) begin
            int gap = int'($urandom % 4);
            for (int g = 0; g < gap; g++) begin
                step(1);
                if (sync_o) stray_sync = 1'b1;
            end
            if (flip_mode && k == n / 2) os128_sel = ~os128_sel;
            lr_tick = 1'b1;
            step(1);
            lr_tick = 1'b0;
            if (sync_o) stray_sync = 1'b1;
        end
    endtask

    task automatic run_cal(input logic os128, input logic flip_mode, input logic poke_busy);
        int unsigned n = frames_needed(os128);
        stray_sync = 1'b0;
        cal_req_in = 1'b1;
        step(2);
        check(sync_o == 1'b0, "R4 no sync after two edges", sync_o, 0);
        step(1);
        check(sync_o == 1'b1 && busy_o == 1'b1, "R4 sync after third edge", sync_o, 1);
        check(gndcal_o == 1'b0, "R5 gnd low during sync", gndcal_o, 0);
        step(1);
        check(sync_o == 1'b0 && gndcal_o == 1'b1 && cal_o == 1'b0, "R5 gnd rises", gndcal_o, 1);
        os128_sel = os128;
        step(1);
        check(cal_o == 1'b1 && gndcal_o == 1'b1, "R5 cal pulse", cal_o, 1);
        if (!poke_busy) cal_req_in = 1'b0;
        step(1);
        check(cal_o == 1'b0 && gndcal_o == 1'b1, "R5 cal one cycle", cal_o, 0);
        if (poke_busy) begin
            cal_req_in = 1'b0;
            step(3);
            cal_req_in = 1'b1;
        end
        drive_ticks(n - 1, flip_mode);
        check(gndcal_o == 1'b1 && busy_o == 1'b1, "R6 R7 still waiting at N-1", gndcal_o, 1);
        lr_tick = 1'b1;
        step(1);
        lr_tick = 1'b0;
        check(gndcal_o == 1'b0 && busy_o == 1'b0, "R6 R7 released at tick N", gndcal_o, 0);
        check(stray_sync == 1'b0, "R8 no sync while busy", stray_sync, 0);
        step(6);
        check(sync_o == 1'b0 && busy_o == 1'b0, "R8 request during busy ignored", busy_o, 0);
        cal_req_in = 1'b0;
        step(4);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R3: request pulse before the strap is captured
        rst = 1'b1;
        step(3);
        rst = 1'b0;
        step(20);
        cal_req_in = 1'b1;
        step(5);
        cal_req_in = 1'b0;
        step(10);
        check(busy_o == 1'b0 && sync_o == 1'b0, "R3 early request ignored", busy_o, 0);

        do_reset(1'b1);
        step(3);
        run_cal(1'b1, 1'b0, 1'b0);
        run_cal(1'b0, 1'b0, 1'b0);
        run_cal(1'b1, 1'b1, 1'b0);
        run_cal(1'b0, 1'b1, 1'b1);
        do_reset(1'b0);
        for (int r = 0; r < 3; r++) begin
            step(1 + int'($urandom % 7));
            run_cal(logic'($urandom % 2), logic'($urandom % 2), logic'($urandom % 2));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule